// File: doc/BRIEF.md
# Sequencing SPI Controller for an Eight-Input ADC

The block is the master side of a four-wire SPI link to an eight-input analog-to-digital converter. It has four lines: a select (active low), a clock that idles high, a master-to-converter data line and a converter-to-master data line. While `run` is high and at least one bit of the channel mask is set, it sends back-to-back frames. The enabled inputs are visited in ascending order and the sequence wraps around. Every frame carries the number of the input to convert next. In the same frame, the converter returns the result of the conversion asked for in the frame before.

Because of this one-frame lag, the controller keeps the number of the input sent in the last frame. It uses that number to label the result that arrives in the following frame. After reset the converter has not been told anything yet, so its first result belongs to input 0. The held number therefore resets to 0. Each finished frame gives one result: a 12-bit unsigned code, its input number, and a valid pulse one cycle long.

Top module: `adc_seq_spi`

## Requirements
- R1: After reset, `adc_cs_n` and `adc_sclk` are 1 and `res_valid` is 0. `adc_sclk` is 1 whenever `adc_cs_n` is 1.
- R2: A frame holds `adc_cs_n` low for exactly 16 falling edges of `adc_sclk`. `adc_mosi` changes after a falling edge. `adc_miso` is sampled on the rising edge that follows.
- R3: The bits of a frame are numbered 1 to 16 in transfer order. The input number goes out on `adc_mosi` in bits 3, 4 and 5, most significant bit first. Every other bit is 0.
- R4: The inputs sent are the set bits of `chan_mask` (bit i enables input i), taken in ascending order with wraparound. After reset the first frame sends the lowest enabled input.
- R5: Each result is labelled with the input number sent in the previous frame.
- R6: The first result after reset is labelled input 0, whatever the first frame requested.
- R7: `res_data` is frame bits 5 to 16 of `adc_miso` read as an unsigned value, most significant bit first. Frame bits 1 to 4 do not affect it.
- R8: `res_valid` is high for exactly one cycle per completed frame, and never two cycles in a row.
- R9: No frame starts while `chan_mask` is zero or `run` is low. A frame already in progress is completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Allows new frames to start |
| chan_mask | input | 8 | Enable bit per converter input |
| adc_miso | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_mosi | output | 1 | Serial data to the converter |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | 12 | Unsigned conversion code |
| res_chan | output | 3 | Input number the result belongs to |

## Verification
The hardest case to reach is the lag between the input number requested and the result labelled with it, because the mismatch only shows when consecutive inputs differ. The most fragile part of that case is the first frame after reset. The bench drives a behavioural converter that returns, for each input, a code built from the input number and the frame count. This converter starts as if input 0 had been requested. With a mask that enables only input 7, the first label must be 0 and only the labels after it may be 7. A sparse mask checks the wraparound order. The converter drives ones into the four leading bits, and the bench checks that none of them reaches the result.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2
  } eng_state_t;
endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [CH_W-1:0]   last_ch,
  input  logic [NUM_CH-1:0] mask,
  output logic [CH_W-1:0]   next_ch,
  output logic              any_en
);
  // candidate at offset k from the last channel sent (k = 1 .. NUM_CH)
  logic [CH_W-1:0] cand [NUM_CH];
  logic [NUM_CH-1:0] cand_en;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_cand
    assign cand[k]    = CH_W'((32'(last_ch) + k + 1) % NUM_CH);
    assign cand_en[k] = mask[cand[k]];
  end

  always_comb begin
    next_ch = last_ch;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (cand_en[k]) next_ch = cand[k];
    end
  end

  assign any_en = |mask;
endmodule

// File: rtl/adc_spi_engine.sv
module adc_spi_engine
  import adc_spi_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CLK_DIV    = 2,
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1,
  localparam int IDX_W = $clog2(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] tx_word,
  input  logic                  miso,
  output logic                  idle,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  mosi,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  done
);
  eng_state_t            state;
  logic [DIV_W-1:0]      div_cnt;
  logic [IDX_W-1:0]      bit_idx;
  logic                  phase_lo;
  logic [FRAME_BITS-1:0] tx_sh;
  logic                  tick;

  assign tick = (32'(div_cnt) == CLK_DIV - 1);
  assign idle = (state == ENG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      div_cnt  <= '0;
      bit_idx  <= '0;
      phase_lo <= 1'b0;
      tx_sh    <= '0;
      rx_word  <= '0;
      cs_n     <= 1'b1;
      sclk     <= 1'b1;
      mosi     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ENG_IDLE) div_cnt <= '0;
      else                   div_cnt <= tick ? '0 : div_cnt + 1'b1;
      unique case (state)
        ENG_IDLE: if (start) begin
          state    <= ENG_SHIFT;
          cs_n     <= 1'b0;
          tx_sh    <= tx_word;
          bit_idx  <= '0;
          phase_lo <= 1'b0;
        end
        ENG_SHIFT: if (tick) begin
          if (!phase_lo) begin
            sclk     <= 1'b0;
            mosi     <= tx_sh[FRAME_BITS-1];
            tx_sh    <= {tx_sh[FRAME_BITS-2:0], 1'b0};
            phase_lo <= 1'b1;
          end else begin
            sclk     <= 1'b1;
            rx_word  <= {rx_word[FRAME_BITS-2:0], miso};
            phase_lo <= 1'b0;
            if (32'(bit_idx) == FRAME_BITS - 1) begin
              state <= ENG_GAP;
              done  <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        ENG_GAP: if (tick) begin
          cs_n  <= 1'b1;
          mosi  <= 1'b0;
          state <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_chan_track.sv
module adc_chan_track #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [CH_W-1:0] load_ch,
  input  logic            done,
  output logic [CH_W-1:0] sent_ch,
  output logic [CH_W-1:0] prev_ch
);
  // sent_ch: channel carried by the frame in flight (also the sequence pointer)
  // prev_ch: channel whose result the converter returns in the current frame
  always_ff @(posedge clk) begin
    if (rst) begin
      sent_ch <= CH_W'(NUM_CH - 1);
      prev_ch <= '0;
    end else begin
      if (load) sent_ch <= load_ch;
      if (done) prev_ch <= sent_ch;
    end
  end
endmodule

// File: rtl/adc_seq_spi.sv
module adc_seq_spi #(
  parameter int NUM_CH     = 8,
  parameter int FRAME_BITS = 16,
  parameter int RES_BITS   = 12,
  parameter int ADDR_POS   = 2,
  parameter int CLK_DIV    = 2,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic [NUM_CH-1:0]   chan_mask,
  input  logic                adc_miso,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic                adc_mosi,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data,
  output logic [CH_W-1:0]     res_chan
);
  localparam int ADDR_TOP = FRAME_BITS - 1 - ADDR_POS;

  logic [CH_W-1:0]       next_ch, sent_ch, prev_ch;
  logic                  any_en, eng_idle, start, done;
  logic [FRAME_BITS-1:0] tx_word, rx_word;

  assign start = run && any_en && eng_idle;

  always_comb begin
    tx_word = '0;
    tx_word[ADDR_TOP -: CH_W] = next_ch;
  end

  adc_chan_pick #(.NUM_CH(NUM_CH)) u_pick (
    .last_ch (sent_ch),
    .mask    (chan_mask),
    .next_ch (next_ch),
    .any_en  (any_en)
  );

  adc_chan_track #(.NUM_CH(NUM_CH)) u_track (
    .clk     (clk),
    .rst     (rst),
    .load    (start),
    .load_ch (next_ch),
    .done    (done),
    .sent_ch (sent_ch),
    .prev_ch (prev_ch)
  );

  adc_spi_engine #(.FRAME_BITS(FRAME_BITS), .CLK_DIV(CLK_DIV)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .tx_word (tx_word),
    .miso    (adc_miso),
    .idle    (eng_idle),
    .cs_n    (adc_cs_n),
    .sclk    (adc_sclk),
    .mosi    (adc_mosi),
    .rx_word (rx_word),
    .done    (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else begin
      res_valid <= done;
      if (done) begin
        res_data <= rx_word[RES_BITS-1:0];
        res_chan <= prev_ch;
      end
    end
  end
endmodule

// File: rtl/adc_seq_spi_chk.sv
module adc_seq_spi_chk #(
  parameter int FRAME_BITS = 16,
  parameter int ADDR_POS   = 2,
  parameter int CH_W       = 3,
  parameter int NUM_CH     = 8,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic [NUM_CH-1:0] chan_mask,
  input logic            adc_cs_n,
  input logic            adc_sclk,
  input logic            adc_mosi,
  input logic            res_valid,
  input logic [CH_W-1:0] res_chan
);
  logic [CNT_W-1:0] fall_n;
  logic             sclk_d, seen_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_n     <= '0;
      sclk_d     <= 1'b1;
      seen_valid <= 1'b0;
    end else begin
      sclk_d <= adc_sclk;
      if (adc_cs_n)                 fall_n <= '0;
      else if (sclk_d && !adc_sclk) fall_n <= fall_n + 1'b1;
      if (res_valid) seen_valid <= 1'b1;
    end
  end

  // R1
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> adc_sclk);

  // R2
  frame_length_chk: assert property (@(posedge clk) disable iff (rst)
    (!adc_cs_n && sclk_d && !adc_sclk) |-> (32'(fall_n) < FRAME_BITS));

  // R3
  pad_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!adc_cs_n && !sclk_d && adc_sclk &&
     ((32'(fall_n) <= ADDR_POS) || (32'(fall_n) > ADDR_POS + CH_W))) |-> !adc_mosi);

  // R6
  first_tag_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !seen_valid) |-> (res_chan == '0));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R9
  no_start_empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_cs_n && (chan_mask == '0)) |=> adc_cs_n);
endmodule

bind adc_seq_spi adc_seq_spi_chk #(
  .FRAME_BITS(FRAME_BITS), .ADDR_POS(ADDR_POS), .CH_W(CH_W), .NUM_CH(NUM_CH)
) u_chk (
  .clk(clk), .rst(rst), .chan_mask(chan_mask), .adc_cs_n(adc_cs_n),
  .adc_sclk(adc_sclk), .adc_mosi(adc_mosi), .res_valid(res_valid),
  .res_chan(res_chan)
);

// File: tb/adc_seq_spi_tb.sv
`timescale 1ns/1ps
module adc_seq_spi_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [7:0]  chan_mask = 8'h00;
  logic        adc_miso = 1'b0;
  logic        adc_cs_n, adc_sclk, adc_mosi, res_valid;
  logic [11:0] res_data;
  logic [2:0]  res_chan;

  always #2.5 clk = ~clk;

  adc_seq_spi u_dut (
    .clk(clk), .rst(rst), .run(run), .chan_mask(chan_mask),
    .adc_miso(adc_miso), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_mosi(adc_mosi), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural converter ----------------
  int          pending = 0;
  int          frame_no = 0;
  int          bitn = 0;
  int          falls = 0;
  logic [15:0] conv_tx = '0;
  logic [15:0] conv_rx = '0;
  int          exp_d[$];
  int          exp_c[$];
  int          sent[$];
  int          tags[$];
  int          n_valid = 0;
  bit          valid_d = 1'b0;

  function automatic logic [11:0] code_of(input int ch, input int fr);
    return {3'(ch), 9'(fr)};
  endfunction

  always @(negedge adc_cs_n) begin
    bitn    = 0;
    falls   = 0;
    conv_rx = '0;
    conv_tx = {4'b1111, code_of(pending, frame_no)};  // leading bits driven high
  end

  always @(negedge adc_sclk) begin
    if (!adc_cs_n) begin
      adc_miso = conv_tx[15 - bitn];
      falls++;
    end
  end

  always @(posedge adc_sclk) begin
    if (!adc_cs_n) begin
      conv_rx = {conv_rx[14:0], adc_mosi};
      bitn++;
      if (bitn == 16) begin
        // R3: only frame bits 3..5 (conv_rx[13:11]) may be set
        check((conv_rx & 16'hC7FF) == 16'h0, "R3 pad bits", int'(conv_rx), int'(conv_rx & 16'h3800));
        // R2: 16 falling edges in the frame
        check(falls == 16, "R2 frame length", falls, 16);
        exp_d.push_back(int'(conv_tx[11:0]));
        exp_c.push_back(pending);
        pending = int'(conv_rx[13:11]);
        sent.push_back(pending);
        frame_no++;
      end
    end
  end

  // ---------------- result monitor ----------------
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        n_valid++;
        // R8
        check(!valid_d, "R8 single-cycle valid", 1, 0);
        check(exp_d.size() > 0, "R8 valid without frame", 0, 1);
        if (exp_d.size() > 0) begin
          int ed, ec;
          ed = exp_d.pop_front();
          ec = exp_c.pop_front();
          // R7
          check(int'(res_data) == ed, "R7 result code", int'(res_data), ed);
          // R5
          check(int'(res_chan) == ec, "R5 result tag", int'(res_chan), ec);
          tags.push_back(int'(res_chan));
        end
      end
      valid_d = res_valid;
    end else begin
      valid_d = 1'b0;
    end
  end

  // ---------------- helpers ----------------
  task automatic restart(input logic [7:0] m);
    run = 1'b0;
    wait (adc_cs_n == 1'b1);
    repeat (10) @(posedge clk);
    #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    pending = 0; frame_no = 0;
    exp_d.delete(); exp_c.delete(); sent.delete(); tags.delete();
    n_valid = 0;
    @(negedge clk);
    // R1
    check(adc_cs_n && adc_sclk && !res_valid, "R1 reset idle",
          int'({adc_cs_n, adc_sclk, res_valid}), 6);
    chan_mask = m;
    rst = 1'b0;
    run = 1'b1;
  endtask

  task automatic wait_frames(input int n);
    wait (sent.size() >= n);
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_power_up;
    restart(8'h80);
    wait_frames(3);
    // R6
    check(tags.size() > 0 && tags[0] == 0, "R6 first tag", tags.size() > 0 ? tags[0] : -1, 0);
    check(int'(sent[0]) == 7, "R4 only channel sent", sent[0], 7);
    // R5
    check(tags.size() > 1 && tags[1] == 7, "R5 second tag", tags.size() > 1 ? tags[1] : -1, 7);
  endtask

  task automatic t_sparse_order;
    int want[6] = '{1, 2, 5, 7, 1, 2};
    restart(8'hA6);
    wait_frames(6);
    for (int i = 0; i < 6; i++)
      check(sent[i] == want[i], "R4 ascending wrap", sent[i], want[i]);
    check(tags[0] == 0, "R6 first tag sparse", tags[0], 0);
  endtask

  task automatic t_full_mask;
    restart(8'hFF);
    wait_frames(9);
    for (int i = 0; i < 9; i++)
      check(sent[i] == (i % 8), "R4 full sweep", sent[i], i % 8);
    check(n_valid >= 8, "R8 valid per frame", n_valid, 8);
  endtask

  task automatic t_empty_mask;
    int f;
    restart(8'h00);
    repeat (400) @(posedge clk);
    @(negedge clk);
    // R9
    check(sent.size() == 0 && adc_cs_n, "R9 empty mask idle", sent.size(), 0);
    chan_mask = 8'h10;
    wait_frames(2);
    check(sent[0] == 4, "R4 mask enabled later", sent[0], 4);
    run = 1'b0;
    wait (adc_cs_n == 1'b1);
    repeat (4) @(posedge clk);
    f = sent.size();
    repeat (400) @(posedge clk);
    @(negedge clk);
    // R9
    check(sent.size() == f && adc_cs_n, "R9 run low", sent.size(), f);
    check(adc_sclk, "R1 clock idles high", int'(adc_sclk), 1);
  endtask

  // ---------------- watchdog & main ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    t_power_up();
    t_sparse_order();
    t_full_mask();
    t_empty_mask();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule